// File: doc/BRIEF.md
# Ethernet Receive Frame Packer

This block takes received Ethernet frames one byte per cycle, with start-of-frame and end-of-frame flags, and packs each accepted frame into a shared byte FIFO. Every frame is stored as a self-describing record. The record begins with a fixed marker word and a header word that carries the stored length and a good-frame status. The frame bytes follow, zero-filled up to the 60-byte minimum. After them comes a CRC-32 over the data and the fill, and then zero bytes up to the next 4-byte boundary. The payload bytes go straight into the FIFO. The marker and header are back-filled into eight reserved bytes once the frame has closed, and only then does the record become visible to the reader.

Software drains the FIFO one 32-bit word at a time through a data-register read strobe. The block keeps its own position inside the current record. The header word loads a remaining-byte counter, and the record retires when that counter runs out. A packet-count register reports how many complete records are waiting, and writing zero to it flushes the whole store. An interrupt flag marks newly stored frames. A ready output tells the sender that room for a maximum-size record is free.

Top module: `rx_frame_packer`

## Requirements
- R1: A frame is stored only if `rxEnable` is high at its start byte and the free FIFO space at its end byte is at least its stored size, 8 + roundup4(max(len,60) + 4). Otherwise nothing of it is kept: the packet count and the free space stay unchanged.
- R2: A frame shorter than 60 bytes is extended with zero bytes to 60. The CRC-32 covers data and fill: reflected polynomial 0xEDB88320, register preset to all ones, result complemented.
- R3: A stored record reads out as the marker word 0x5AA5C33C, then a header word with status 16'h0001 in bits 31:16 and the padded length plus 4 in bits 15:0, then data and fill, then the CRC word, then zero bytes up to a 4-byte boundary.
- R4: The bytes of each word are ordered least significant first: the earliest byte sits in bits 7:0. The CRC word is therefore stored low byte first.
- R5: Each stored frame raises `pktCount` by one and sets `rxIrq`. A pulse on `irqClr` clears `rxIrq`, and a store in the same cycle takes priority over the clear.
- R6: The first read of a record returns the marker and the second returns the header. The header's low 16 bits, rounded up to a multiple of 4, give the number of bytes still to read. Each later read takes 4 off that number, and when it reaches zero `pktCount` drops by one and the next read returns the following record's marker.
- R7: While `pktCount` is zero, `rdData` reads 0 and a read strobe changes no state.
- R8: A count-register write of 0 empties the FIFO and clears the packet count, the read position and the remaining length. A write of any other value has no effect.
- R9: `rxReady` is high exactly when at least 1532 bytes of the 2048-byte FIFO are free.
- R10: A record that completes in the same cycle as the final read of another record is counted, and that final read is also counted. `pktCount` is left with the net result of both.
- R11: A frame whose start byte arrives while the previous frame's fill, CRC and header are still being written is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receive enable, sampled at each start byte |
| inValid | input | 1 | A frame byte is present on `inData` |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | Current byte is the first of a frame |
| inEof | input | 1 | Current byte is the last of a frame |
| rdEn | input | 1 | Data-register read strobe; consumes the word shown on `rdData` |
| rdData | output | 32 | Word at the head of the FIFO, or 0 when no record is stored |
| cntWrEn | input | 1 | Write strobe for the packet-count register |
| cntWrData | input | 16 | Value written to the packet-count register |
| pktCount | output | 16 | Number of complete records stored |
| irqClr | input | 1 | Clears the receive interrupt flag |
| rxIrq | output | 1 | Receive interrupt flag |
| rxReady | output | 1 | At least 1532 bytes free |

## Verification
Two things can land in the same clock edge: the write side committing a newly sealed record, which adds its size to the used space and raises the count, and the read side popping the last word of the oldest record, which lowers both. The bench reads an earlier 60-byte record down to its final word. It then streams a 64-byte frame and times the final read strobe to the edge that writes the new header's last byte, twelve edges after the end byte. It judges the result by the count left behind (one) and by reading out the new record intact, word for word. The random phase also mixes frames and read bursts, so the two updates meet at other offsets.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  localparam int HDR_BYTES = 8;
  localparam int MIN_FRAME = 60;
  localparam int CRC_BYTES = 4;
  localparam int LW        = 18;

  localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
  localparam logic [15:0] STATUS_OK = 16'h0001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_PAD,
    ST_CRC,
    ST_ALIGN,
    ST_HDR
  } packState_e;

  typedef enum logic [1:0] {
    SRC_INPUT,
    SRC_ZERO,
    SRC_CRC,
    SRC_HDR
  } byteSrc_e;

  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic        wrEn;
    logic [15:0] wrOff;        // byte offset from the current record base
    byteSrc_e    src;
    logic [1:0]  lane;         // CRC byte lane
    logic [15:0] hdrLen;       // value for header bits 15:0
    logic        crcStart;
    logic        crcStep;
    logic        commit;
    logic [15:0] commitBytes;
    logic        pop;
    logic        flush;
  } dpStrobe_t;

  function automatic logic [31:0] crcStepByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] roundUp4(input logic [LW-1:0] v);
    logic [LW-1:0] t;
    t = v + LW'(3);
    return {t[LW-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/rxpk_dpath.sv
module rxpk_dpath
  import rxpk_pkg::*;
#(
  parameter int          DEPTH_BYTES = 2048,
  parameter logic [31:0] MARKER      = 32'h5AA5_C33C
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] inData,
  output logic [31:0] headWord
);

  localparam int AW = $clog2(DEPTH_BYTES);

  logic [7:0]    mem [DEPTH_BYTES];
  logic [AW-1:0] wrBase;
  logic [AW-1:0] rdPtr;
  logic [31:0]   crcReg;
  logic [7:0]    wrByte;
  logic [31:0]   crcOut;
  logic [31:0]   hdrWord;
  logic [31:0]   hdrSel;

  assign crcOut  = ~crcReg;
  assign hdrWord = {STATUS_OK, stb.hdrLen};
  assign hdrSel  = stb.wrOff[2] ? hdrWord : MARKER;

  always_comb begin
    case (stb.src)
      SRC_INPUT: wrByte = inData;
      SRC_ZERO:  wrByte = 8'h00;
      SRC_CRC:   wrByte = crcOut[{stb.lane, 3'b000} +: 8];
      default:   wrByte = hdrSel[{stb.wrOff[1:0], 3'b000} +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      mem[wrBase + stb.wrOff[AW-1:0]] <= wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBase <= '0;
      rdPtr  <= '0;
      crcReg <= '1;
    end else begin
      if (stb.crcStart) begin
        crcReg <= crcStepByte('1, wrByte);
      end else if (stb.crcStep) begin
        crcReg <= crcStepByte(crcReg, wrByte);
      end
      if (stb.flush) begin
        wrBase <= '0;
        rdPtr  <= '0;
      end else begin
        if (stb.commit) wrBase <= wrBase + stb.commitBytes[AW-1:0];
        if (stb.pop)    rdPtr  <= rdPtr + AW'(4);
      end
    end
  end

  assign headWord = {mem[rdPtr + AW'(3)], mem[rdPtr + AW'(2)],
                     mem[rdPtr + AW'(1)], mem[rdPtr]};

  logic unusedBits;
  assign unusedBits = ^{stb.wrOff[15:AW], stb.commitBytes[15:AW]};

  // R8: a flush returns both pointers to the start of the store
  p_flush_ptr_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (rdPtr == '0 && wrBase == '0));

endmodule

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
#(
  parameter int DEPTH_BYTES = 2048,
  parameter int READY_FREE  = 1532
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        rdEn,
  input  logic [31:0] headWord,
  input  logic        cntWrEn,
  input  logic [15:0] cntWrData,
  input  logic        irqClr,
  output dpStrobe_t   stb,
  output logic [31:0] rdData,
  output logic [15:0] pktCount,
  output logic        rxIrq,
  output logic        rxReady
);

  localparam int AW = $clog2(DEPTH_BYTES);
  localparam int UW = AW + 1;
  localparam logic [1:0] POS_MARK = 2'd0;
  localparam logic [1:0] POS_HDR  = 2'd1;
  localparam logic [1:0] POS_DATA = 2'd2;

  packState_e    state;
  logic [15:0]   off, cnt, padLen, totLen, crcEnd, remain, pktCnt;
  logic          ovf, irq;
  logic [UW-1:0] used;
  logic [1:0]    pos;

  logic          flush, byteIn, startB, contB, abortB, takeB, ovfN, fits;
  logic          popReq, lastPop;
  logic [LW-1:0] freeL, dataOff, padN, totalN;
  logic [15:0]   cntN;
  logic [UW-1:0] usedNext;

  assign flush   = cntWrEn && (cntWrData == 16'h0);
  assign byteIn  = inValid && !flush;
  assign startB  = byteIn && inSof && rxEnable && (state == ST_IDLE || state == ST_RECV);
  assign contB   = byteIn && !inSof && (state == ST_RECV);
  assign abortB  = byteIn && inSof && !rxEnable && (state == ST_RECV);
  assign takeB   = startB || contB;

  assign freeL   = LW'(DEPTH_BYTES) - LW'(used);
  assign dataOff = LW'(HDR_BYTES) + (startB ? '0 : LW'(cnt));
  assign ovfN    = (startB ? 1'b0 : ovf) || !(dataOff < freeL);
  assign cntN    = startB ? 16'd1 : cnt + 16'd1;
  assign padN    = (cntN < 16'(MIN_FRAME)) ? LW'(MIN_FRAME) : LW'(cntN);
  assign totalN  = LW'(HDR_BYTES) + roundUp4(padN + LW'(CRC_BYTES));
  assign fits    = !ovfN && (totalN <= freeL);

  assign popReq  = rdEn && (pktCnt != 16'h0) && !flush;
  assign lastPop = popReq && (pos == POS_DATA) && (remain == 16'd4);

  always_comb begin
    stb             = '0;
    stb.flush       = flush;
    stb.pop         = popReq;
    stb.hdrLen      = padLen + 16'd4;
    stb.commitBytes = totLen;
    if (!flush) begin
      case (state)
        ST_IDLE, ST_RECV: begin
          if (takeB) begin
            stb.wrEn     = !ovfN;
            stb.wrOff    = 16'(dataOff);
            stb.src      = SRC_INPUT;
            stb.crcStart = startB;
            stb.crcStep  = contB;
          end
        end
        ST_PAD: begin
          stb.wrEn    = 1'b1;
          stb.wrOff   = off;
          stb.src     = SRC_ZERO;
          stb.crcStep = 1'b1;
        end
        ST_CRC: begin
          stb.wrEn  = 1'b1;
          stb.wrOff = off;
          stb.src   = SRC_CRC;
          stb.lane  = 2'(off - crcEnd);
        end
        ST_ALIGN: begin
          stb.wrEn  = 1'b1;
          stb.wrOff = off;
          stb.src   = SRC_ZERO;
        end
        ST_HDR: begin
          stb.wrEn   = 1'b1;
          stb.wrOff  = off;
          stb.src    = SRC_HDR;
          stb.commit = (off == 16'd7);
        end
        default: ;
      endcase
    end
  end

  assign usedNext = used + (stb.commit ? UW'(totLen) : UW'(0)) - (popReq ? UW'(4) : UW'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      off    <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      padLen <= '0;
      totLen <= '0;
      crcEnd <= '0;
      used   <= '0;
      pktCnt <= '0;
      pos    <= POS_MARK;
      remain <= '0;
      irq    <= 1'b0;
    end else begin
      if (stb.commit)  irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;

      if (flush) begin
        state  <= ST_IDLE;
        ovf    <= 1'b0;
        used   <= '0;
        pktCnt <= '0;
        pos    <= POS_MARK;
        remain <= '0;
      end else begin
        used <= usedNext;
        case ({stb.commit, lastPop})
          2'b10:   pktCnt <= pktCnt + 16'd1;
          2'b01:   pktCnt <= pktCnt - 16'd1;
          default: ;
        endcase

        if (popReq) begin
          case (pos)
            POS_MARK: pos <= POS_HDR;
            POS_HDR: begin
              pos    <= POS_DATA;
              remain <= 16'(roundUp4(LW'(headWord[15:0])));
            end
            default: begin
              remain <= remain - 16'd4;
              if (remain == 16'd4) pos <= POS_MARK;
            end
          endcase
        end

        case (state)
          ST_IDLE, ST_RECV: begin
            if (takeB) begin
              cnt <= cntN;
              ovf <= ovfN;
              if (inEof) begin
                if (fits) begin
                  padLen <= 16'(padN);
                  totLen <= 16'(totalN);
                  crcEnd <= 16'(LW'(HDR_BYTES) + padN);
                  off    <= 16'(dataOff + LW'(1));
                  state  <= (cntN < 16'(MIN_FRAME)) ? ST_PAD : ST_CRC;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_RECV;
              end
            end else if (abortB) begin
              state <= ST_IDLE;
            end
          end
          ST_PAD: begin
            off <= off + 16'd1;
            if (off + 16'd1 == crcEnd) state <= ST_CRC;
          end
          ST_CRC: begin
            if (off == crcEnd + 16'd3) begin
              if (off + 16'd1 == totLen) begin
                state <= ST_HDR;
                off   <= '0;
              end else begin
                state <= ST_ALIGN;
                off   <= off + 16'd1;
              end
            end else begin
              off <= off + 16'd1;
            end
          end
          ST_ALIGN: begin
            if (off + 16'd1 == totLen) begin
              state <= ST_HDR;
              off   <= '0;
            end else begin
              off <= off + 16'd1;
            end
          end
          ST_HDR: begin
            off <= off + 16'd1;
            if (off == 16'd7) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rdData   = (pktCnt != 16'h0) ? headWord : 32'h0;
  assign pktCount = pktCnt;
  assign rxIrq    = irq;
  assign rxReady  = freeL >= LW'(READY_FREE);

  // R7: a read with nothing stored leaves the read side untouched
  p_idle_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && pktCnt == 16'h0 && !flush && !stb.commit) |=>
      ($stable(used) && $stable(pos) && $stable(pktCnt)));

  // R8: a zero write clears count, position and occupancy
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (pktCnt == 16'h0 && pos == POS_MARK && used == '0));

  // R5: a sealed record always leaves the flag raised
  p_commit_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> rxIrq);

  // R6: with no record waiting the reader sits at a record start
  p_pos_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pktCnt == 16'h0) |-> (pos == POS_MARK));

  // R1: occupancy never exceeds the store
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    used <= UW'(DEPTH_BYTES));

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxpk_pkg::*;
#(
  parameter int          DEPTH_BYTES = 2048,
  parameter int          READY_FREE  = 1532,
  parameter logic [31:0] MARKER      = 32'h5AA5_C33C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxEnable,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        rdEn,
  output logic [31:0] rdData,
  input  logic        cntWrEn,
  input  logic [15:0] cntWrData,
  output logic [15:0] pktCount,
  input  logic        irqClr,
  output logic        rxIrq,
  output logic        rxReady
);

  dpStrobe_t   stb;
  logic [31:0] headWord;

  rxpk_ctrl #(
    .DEPTH_BYTES(DEPTH_BYTES),
    .READY_FREE (READY_FREE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .inValid  (inValid),
    .inSof    (inSof),
    .inEof    (inEof),
    .rdEn     (rdEn),
    .headWord (headWord),
    .cntWrEn  (cntWrEn),
    .cntWrData(cntWrData),
    .irqClr   (irqClr),
    .stb      (stb),
    .rdData   (rdData),
    .pktCount (pktCount),
    .rxIrq    (rxIrq),
    .rxReady  (rxReady)
  );

  rxpk_dpath #(
    .DEPTH_BYTES(DEPTH_BYTES),
    .MARKER     (MARKER)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .headWord(headWord)
  );

endmodule

// File: tb/tb_rx_frame_packer.sv
module tb_rx_frame_packer;

  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h0;
  logic        inSof = 1'b0;
  logic        inEof = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        cntWrEn = 1'b0;
  logic [15:0] cntWrData = 16'h0;
  logic [15:0] pktCount;
  logic        irqClr = 1'b0;
  logic        rxIrq;
  logic        rxReady;

  rx_frame_packer dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .inValid(inValid),
    .inData(inData), .inSof(inSof), .inEof(inEof), .rdEn(rdEn),
    .rdData(rdData), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .pktCount(pktCount), .irqClr(irqClr), .rxIrq(rxIrq), .rxReady(rxReady)
  );

  always #4 clk = ~clk;

  int          nChk = 0;
  int          nFail = 0;
  bit          done = 1'b0;
  logic [7:0]  fb [0:1599];
  logic [7:0]  wb [0:2047];
  logic [31:0] expQ[$];
  bit          lastQ[$];
  string       tagQ[$];
  int          expCnt = 0;
  int          expUsed = 0;
  bit          expIrq = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrc(input int len, input int padded);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < padded; i++) begin
      logic [7:0] b = (i < len) ? fb[i] : 8'h00;
      c = c ^ {24'h0, b};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic int storedSize(input int len);
    int p = (len < 60) ? 60 : len;
    return 8 + (((p + 4) + 3) / 4) * 4;
  endfunction

  task automatic addExpected(input int len);
    int p = (len < 60) ? 60 : len;
    int n = 0;
    int total = storedSize(len);
    logic [31:0] crc = refCrc(len, p);
    logic [31:0] hdr = {16'h0001, 16'(p + 4)};
    logic [31:0] mk = 32'h5AA5_C33C;
    for (int k = 0; k < 4; k++) begin wb[n] = mk[8*k +: 8]; n++; end
    for (int k = 0; k < 4; k++) begin wb[n] = hdr[8*k +: 8]; n++; end
    for (int i = 0; i < p; i++) begin wb[n] = (i < len) ? fb[i] : 8'h00; n++; end
    for (int k = 0; k < 4; k++) begin wb[n] = crc[8*k +: 8]; n++; end
    while (n < total) begin wb[n] = 8'h00; n++; end
    for (int w = 0; w < total / 4; w++) begin
      expQ.push_back({wb[4*w+3], wb[4*w+2], wb[4*w+1], wb[4*w]});
      lastQ.push_back(w == total / 4 - 1);
      if (w == 0)      tagQ.push_back("R3 marker");
      else if (w == 1) tagQ.push_back("R3 header");
      else             tagQ.push_back("R2/R4 body");
    end
    expUsed += total;
    expCnt++;
    expIrq = 1'b1;
  endtask

  // Model decision for a frame about to be sent (R1)
  task automatic modelFrame(input int len);
    if (rxEnable && storedSize(len) <= DEPTH - expUsed) addExpected(len);
  endtask

  task automatic fillFrame(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom_range(0, 255));
  endtask

  task automatic driveBytes(input int len);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = fb[i];
      inSof   = (i == 0);
      inEof   = (i == len - 1);
      @(negedge clk);
    end
    inValid = 1'b0;
    inSof   = 1'b0;
    inEof   = 1'b0;
  endtask

  task automatic sendFrame(input int len);
    fillFrame(len);
    modelFrame(len);
    driveBytes(len);
    repeat (80) @(negedge clk);
  endtask

  task automatic readWord();
    logic [31:0] exp = 32'h0;
    string tag = "R7 empty read";
    if (expCnt > 0) begin
      exp = expQ[0];
      tag = tagQ[0];
    end
    check(tag, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    if (expCnt > 0) begin
      if (lastQ[0]) expCnt--;
      void'(expQ.pop_front());
      void'(lastQ.pop_front());
      void'(tagQ.pop_front());
      expUsed -= 4;
    end
  endtask

  task automatic checkStatus(input string req);
    check({req, " count"}, 32'(pktCount), 32'(expCnt));
    check("R9 ready", 32'(rxReady), 32'((DEPTH - expUsed) >= 1532));
    check("R5 irq", 32'(rxIrq), 32'(expIrq));
  endtask

  task automatic flushFifo();
    cntWrEn = 1'b1;
    cntWrData = 16'h0;
    @(negedge clk);
    cntWrEn = 1'b0;
    expQ.delete();
    lastQ.delete();
    tagQ.delete();
    expCnt = 0;
    expUsed = 0;
  endtask

  task automatic clearIrq();
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
    expIrq = 1'b0;
  endtask

  task automatic drainAll(input string req);
    while (expCnt > 0) readWord();
    checkStatus(req);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    checkStatus("R5 reset");
    check("R7 reset rdData", rdData, 32'h0);

    // R7: read while empty
    readWord();
    checkStatus("R7");

    // R1: receive disabled drops the frame
    rxEnable = 1'b0;
    sendFrame(64);
    checkStatus("R1 disabled");

    // R2/R3/R4/R6: short frame, then retire
    rxEnable = 1'b1;
    sendFrame(10);
    checkStatus("R5 stored");
    drainAll("R6 retired");
    clearIrq();
    checkStatus("R5 cleared");

    // R3: alignment padding after CRC (61 bytes)
    sendFrame(61);
    check("R6 used", 32'(rxReady), 32'(1));
    drainAll("R6 aligned");

    // R8: nonzero write ignored, zero write flushes
    sendFrame(100);
    cntWrEn = 1'b1; cntWrData = 16'd5;
    @(negedge clk);
    cntWrEn = 1'b0;
    checkStatus("R8 nonzero ignored");
    readWord();
    flushFifo();
    checkStatus("R8 flush");
    check("R8 rdData after flush", rdData, 32'h0);

    // R9 boundary: exactly 1532 free, then 1528 free
    sendFrame(504);
    check("R9 ready at 1532 free", 32'(rxReady), 32'(1));
    flushFifo();
    sendFrame(505);
    check("R9 ready at 1528 free", 32'(rxReady), 32'(0));
    flushFifo();

    // R1: fill until a frame no longer fits
    for (int f = 0; f < 10; f++) sendFrame(200);
    checkStatus("R1 full");
    drainAll("R1 drained");

    // R11: second frame starts while the first is being sealed
    fillFrame(64);
    modelFrame(64);
    driveBytes(64);
    fillFrame(64);
    driveBytes(64);
    repeat (80) @(negedge clk);
    checkStatus("R11 busy drop");
    drainAll("R11 drained");

    // R10: commit and final read of another record on the same edge
    flushFifo();
    sendFrame(60);
    for (int w = 0; w < 17; w++) readWord();
    fillFrame(64);
    modelFrame(64);
    driveBytes(64);
    repeat (11) @(negedge clk);
    readWord();
    repeat (10) @(negedge clk);
    checkStatus("R10 coincident");
    drainAll("R10 drained");

    // Random mix
    for (int it = 0; it < 260; it++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 5) begin
        rxEnable = ($urandom_range(0, 9) != 0);
        sendFrame($urandom_range(1, 300));
      end else if (sel < 9) begin
        int nw = $urandom_range(1, 40);
        for (int k = 0; k < nw; k++) readWord();
      end else begin
        clearIrq();
      end
      checkStatus("R1 random");
    end
    drainAll("R6 final");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule